// File: doc/BRIEF.md
# Register-Write Command Stream Executor

This block walks a buffer of 32-bit command words and turns each command into single-word writes on a plain offset/data write bus. The first word of every command carries an 8-bit opcode in bits [31:24] that selects the command type and its fixed header length. Three families of commands produce writes: a run of consecutive registers, a list of independent offset/value pairs, and lookup-table loads that push payload words into a data port. A fourth command switches the active register window by matching a 24-bit base against a small table of window bases and sizes supplied on input ports.

Software fills the buffer, sets the buffer length in words and pulses `start`. The executor reads one word per cycle over a combinational read port, checks each command in full (opcode, header presence, payload length against the words left in the buffer, and every target offset against the size of the active window) before it issues any write for it. It stops at the first bad command with a sticky error and a record of the failing opcode and the word index where that command began. Reaching the end of the buffer cleanly raises `done`. Both flags hold until the next `start`.

Top module: `cmd_stream_exec`

## Requirements
- R1: The opcode is word0[31:24]; supported codes are 1, 3, 4, 8, 10 and 11. Any other code stops execution with `err`=1, `errOp` equal to that code and `errIdx` equal to the word index of the command's first word.
- R2: Opcode 3 (two-word header) takes a count from word0[15:0] and a start byte offset from word1[23:0], then writes the next count words, in order, to offsets start, start+4, start+8 and so on.
- R3: Opcode 4 (one-word header) takes a count from word0[15:0] and is followed by count pairs of words (offset, value); each pair gives one write of the value at the offset taken from bits [23:0] of the offset word, in buffer order.
- R4: A count of zero in opcode 3 or 4 is an error.
- R5: Opcode 1 (three-word header: word0[15:0] = byte count minus one, word1 ignored, word2[23:0] = data-port offset) writes (len+1)/4 payload words, rounded down, each to data-port offset + 8; a result of zero words issues no write.
- R6: Opcode 10 uses the same header and word count as opcode 1 but writes each word to data-port offset + 12.
- R7: Opcode 11 uses the same header and writes (len+1)/8 beats, rounded down, of two words each: the first word of a beat to data-port offset + 12, the second to data-port offset + 8.
- R8: Opcode 8 (one word, base in [23:0]) makes the lowest-indexed window whose base equals it active, and every later write reports that window's index on `wrWin`; with no matching base, execution stops with an error.
- R9: Each write offset must be below the active window size (zero while no window is active); a command with any offset at or beyond it is an error and none of its writes are issued, including the earlier pairs of an opcode-4 command.
- R10: A table load (opcode 1, 10 or 11) issued before any window is active is an error.
- R11: A command whose header or declared payload extends past the buffer length is an error and none of its writes are issued.
- R12: `err` and `done` are sticky and mutually exclusive; after either, `busy` is low and no write occurs until `start`, which clears both flags and the active window. An empty buffer gives `done` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse to begin executing from word 0 |
| bufLen | input | IDXW | Number of valid words in the buffer |
| bufRdAddr | output | IDXW | Word index being read |
| bufRdData | input | 32 | Buffer word at `bufRdAddr`, same cycle |
| winBase | input | NUM_WIN*24 | Packed window base table, entry i in bits [24i+23:24i] |
| winSize | input | NUM_WIN*24 | Packed window size table in bytes, same packing |
| wrEn | output | 1 | Write strobe, one write per cycle |
| wrWin | output | WINW | Index of the active window for this write |
| wrOfs | output | 24 | Byte offset within the window |
| wrData | output | 32 | Write data |
| busy | output | 1 | Executor is running |
| done | output | 1 | Sticky: buffer finished without error |
| err | output | 1 | Sticky: execution stopped on a bad command |
| errOp | output | 8 | Opcode of the failing command |
| errIdx | output | IDXW | Word index of the failing command's first word |

## Verification
The checker watches, on every cycle, that writes only happen while running and never after an error, that each write offset lies inside the size of the window it names, that the buffer word feeding a write is inside the buffer, and that the status flags stay sticky, exclusive and settled when `busy` drops. What those cycle rules cannot show is the order and address of the writes each opcode produces, the per-variant data-port offsets, the rejection of a whole command when only a late pair or a late word is bad, and the recorded opcode and index; the bench scenarios cover these by predicting every write and every final status word.

// File: rtl/cse_pkg.sv
package cse_pkg;
  localparam int WORDW = 32;
  localparam int OFSW  = 24;

  localparam logic [7:0] OP_TBL   = 8'd1;
  localparam logic [7:0] OP_CONT  = 8'd3;
  localparam logic [7:0] OP_RAND  = 8'd4;
  localparam logic [7:0] OP_BASE  = 8'd8;
  localparam logic [7:0] OP_TBL32 = 8'd10;
  localparam logic [7:0] OP_TBL64 = 8'd11;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECODE, S_HDR, S_CHECK, S_SCAN, S_RADDR, S_EXEC
  } stateT;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic init;
    logic latchW0;
    logic latchHdr;
    logic advance;
    logic skip;
    logic rewind;
    logic setBase;
    logic loadCnt;
    logic decCnt;
    logic latchOfs;
    logic write;
    logic setDone;
    logic setFail;
  } strobeT;

  // Header length in words; zero marks an unsupported opcode
  function automatic logic [1:0] hdrLen(input logic [7:0] op);
    case (op)
      OP_TBL, OP_TBL32, OP_TBL64: hdrLen = 2'd3;
      OP_CONT:                    hdrLen = 2'd2;
      OP_RAND, OP_BASE:           hdrLen = 2'd1;
      default:                    hdrLen = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/cse_ctrl.sv
module cse_ctrl
  import cse_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] op,
  input  logic       atEnd,
  input  logic       hdrFits,
  input  logic       lastHdr,
  input  logic       cntZero,
  input  logic       cmdFits,
  input  logic       contOk,
  input  logic       tableOk,
  input  logic       baseHit,
  input  logic       scanOk,
  input  logic       cntLast,
  input  logic       payNone,
  output strobeT     stb,
  output logic       busy
);
  stateT state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  assign busy = (state != S_IDLE);

  always_comb begin
    stb = '0;
    nxt = state;
    case (state)
      S_IDLE: if (start) begin
        stb.init = 1'b1;
        nxt = S_FETCH;
      end
      S_FETCH: begin
        if (atEnd) begin
          stb.setDone = 1'b1;
          nxt = S_IDLE;
        end else begin
          stb.latchW0 = 1'b1;
          stb.advance = 1'b1;
          nxt = S_DECODE;
        end
      end
      S_DECODE: begin
        if (hdrLen(op) == 2'd0 || !hdrFits) begin
          stb.setFail = 1'b1;
          nxt = S_IDLE;
        end else if (hdrLen(op) == 2'd1) begin
          nxt = S_CHECK;
        end else begin
          nxt = S_HDR;
        end
      end
      S_HDR: begin
        stb.latchHdr = 1'b1;
        stb.advance  = 1'b1;
        if (lastHdr) nxt = S_CHECK;
      end
      S_CHECK: begin
        case (op)
          OP_BASE: begin
            if (baseHit) begin
              stb.setBase = 1'b1;
              nxt = S_FETCH;
            end else begin
              stb.setFail = 1'b1;
              nxt = S_IDLE;
            end
          end
          OP_CONT: begin
            if (cntZero || !cmdFits || !contOk) begin
              stb.setFail = 1'b1;
              nxt = S_IDLE;
            end else begin
              stb.loadCnt = 1'b1;
              nxt = S_EXEC;
            end
          end
          OP_RAND: begin
            if (cntZero || !cmdFits) begin
              stb.setFail = 1'b1;
              nxt = S_IDLE;
            end else begin
              stb.loadCnt = 1'b1;
              nxt = S_SCAN;
            end
          end
          default: begin
            if (!cmdFits || !tableOk) begin
              stb.setFail = 1'b1;
              nxt = S_IDLE;
            end else if (payNone) begin
              nxt = S_FETCH;
            end else begin
              stb.loadCnt = 1'b1;
              nxt = S_EXEC;
            end
          end
        endcase
      end
      S_SCAN: begin
        if (!scanOk) begin
          stb.setFail = 1'b1;
          nxt = S_IDLE;
        end else if (cntLast) begin
          stb.rewind = 1'b1;
          nxt = S_RADDR;
        end else begin
          stb.skip   = 1'b1;
          stb.decCnt = 1'b1;
        end
      end
      S_RADDR: begin
        stb.latchOfs = 1'b1;
        stb.advance  = 1'b1;
        nxt = S_EXEC;
      end
      S_EXEC: begin
        stb.write   = 1'b1;
        stb.advance = 1'b1;
        stb.decCnt  = 1'b1;
        if (cntLast)            nxt = S_FETCH;
        else if (op == OP_RAND) nxt = S_RADDR;
      end
      default: nxt = S_IDLE;
    endcase
  end
endmodule

// File: rtl/cse_dpath.sv
module cse_dpath
  import cse_pkg::*;
#(
  parameter int IDXW    = 10,
  parameter int NUM_WIN = 4,
  localparam int WINW   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobeT                  stb,
  input  logic [IDXW-1:0]         bufLen,
  input  logic [WORDW-1:0]        bufRdData,
  input  logic [NUM_WIN*OFSW-1:0] winBase,
  input  logic [NUM_WIN*OFSW-1:0] winSize,
  output logic [IDXW-1:0]         bufRdAddr,
  output logic [7:0]              op,
  output logic                    atEnd,
  output logic                    hdrFits,
  output logic                    lastHdr,
  output logic                    cntZero,
  output logic                    cmdFits,
  output logic                    contOk,
  output logic                    tableOk,
  output logic                    baseHit,
  output logic                    scanOk,
  output logic                    cntLast,
  output logic                    payNone,
  output logic [WINW-1:0]         wrWin,
  output logic [OFSW-1:0]         wrOfs,
  output logic [WORDW-1:0]        wrData,
  output logic                    done,
  output logic                    err,
  output logic [7:0]              errOp,
  output logic [IDXW-1:0]         errIdx
);
  localparam int SUMW = IDXW + 19;

  logic [OFSW-1:0] baseArr [NUM_WIN];
  logic [OFSW-1:0] sizeArr [NUM_WIN];

  generate
    for (genvar g = 0; g < NUM_WIN; g++) begin : gWin
      assign baseArr[g] = winBase[g*OFSW +: OFSW];
      assign sizeArr[g] = winSize[g*OFSW +: OFSW];
    end
  endgenerate

  logic [IDXW-1:0] rdPtr, cmdIdx;
  logic [7:0]      opQ;
  logic [OFSW-1:0] w0Lo, w1Ofs, dport, curOfs;
  logic [16:0]     remCnt;
  logic            phase;
  logic [WINW-1:0] actWin, hitIdx;
  logic            baseValid;

  logic [15:0]     cnt;
  logic [1:0]      hl;
  logic [16:0]     lenP1;
  logic [17:0]     payWords;
  logic [OFSW-1:0] winSz;
  logic [26:0]     contLast;
  logic [24:0]     tblEdge;

  assign op        = opQ;
  assign cnt       = w0Lo[15:0];
  assign hl        = hdrLen(opQ);
  assign bufRdAddr = rdPtr;
  assign atEnd     = (rdPtr >= bufLen);
  assign lenP1     = {1'b0, cnt} + 17'd1;
  assign winSz     = baseValid ? sizeArr[actWin] : '0;

  always_comb begin
    case (opQ)
      OP_CONT:          payWords = {2'b00, cnt};
      OP_RAND:          payWords = {1'b0, cnt, 1'b0};
      OP_TBL64:         payWords = 18'(lenP1 >> 3) << 1;
      default:          payWords = 18'(lenP1 >> 2);
    endcase
  end

  assign hdrFits  = (SUMW'(cmdIdx) + SUMW'(hl)) <= SUMW'(bufLen);
  assign cmdFits  = (SUMW'(cmdIdx) + SUMW'(hl) + SUMW'(payWords)) <= SUMW'(bufLen);
  assign lastHdr  = (rdPtr - cmdIdx) == (IDXW'(hl) - IDXW'(1));
  assign cntZero  = (cnt == 16'd0);
  assign contLast = 27'(w1Ofs) + {9'd0, cnt - 16'd1, 2'b00};
  assign contOk   = contLast < 27'(winSz);
  assign tblEdge  = {1'b0, dport} + ((opQ == OP_TBL) ? 25'd8 : 25'd12);
  assign tableOk  = baseValid && (tblEdge < {1'b0, winSz});
  assign scanOk   = bufRdData[OFSW-1:0] < winSz;
  assign cntLast  = (remCnt == 17'd1);
  assign payNone  = (payWords == 18'd0);

  // Lowest-indexed matching window wins
  always_comb begin
    baseHit = 1'b0;
    hitIdx  = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (baseArr[i] == w0Lo) begin
        baseHit = 1'b1;
        hitIdx  = WINW'(i);
      end
    end
  end

  always_comb begin
    case (opQ)
      OP_TBL:   wrOfs = dport + 24'd8;
      OP_TBL32: wrOfs = dport + 24'd12;
      OP_TBL64: wrOfs = phase ? dport + 24'd8 : dport + 24'd12;
      default:  wrOfs = curOfs;
    endcase
  end

  assign wrData = bufRdData;
  assign wrWin  = actWin;
  assign done   = 1'b0 | doneQ;
  assign err    = errQ;
  assign errOp  = errOpQ;
  assign errIdx = errIdxQ;

  logic            doneQ, errQ;
  logic [7:0]      errOpQ;
  logic [IDXW-1:0] errIdxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;  cmdIdx <= '0;  opQ <= '0;   w0Lo <= '0;
      w1Ofs <= '0;  dport <= '0;   curOfs <= '0; remCnt <= '0;
      phase <= 1'b0; actWin <= '0; baseValid <= 1'b0;
      doneQ <= 1'b0; errQ <= 1'b0; errOpQ <= '0; errIdxQ <= '0;
    end else begin
      if (stb.init) begin
        rdPtr <= '0;  cmdIdx <= '0;  baseValid <= 1'b0;
        doneQ <= 1'b0; errQ <= 1'b0; errOpQ <= '0; errIdxQ <= '0;
      end else if (stb.rewind) begin
        rdPtr <= cmdIdx + IDXW'(1);
      end else if (stb.skip) begin
        rdPtr <= rdPtr + IDXW'(2);
      end else if (stb.advance) begin
        rdPtr <= rdPtr + IDXW'(1);
      end

      if (stb.latchW0) begin
        opQ    <= bufRdData[31:24];
        w0Lo   <= bufRdData[OFSW-1:0];
        cmdIdx <= rdPtr;
      end
      if (stb.latchHdr) begin
        if ((rdPtr - cmdIdx) == IDXW'(1)) w1Ofs <= bufRdData[OFSW-1:0];
        else                              dport <= bufRdData[OFSW-1:0];
      end

      if (stb.loadCnt) begin
        remCnt <= (opQ == OP_RAND) ? {1'b0, cnt} : payWords[16:0];
        curOfs <= w1Ofs;
        phase  <= 1'b0;
      end else if (stb.rewind) begin
        remCnt <= {1'b0, cnt};
      end else if (stb.decCnt) begin
        remCnt <= remCnt - 17'd1;
      end

      if (stb.latchOfs) curOfs <= bufRdData[OFSW-1:0];
      else if (stb.write) curOfs <= curOfs + 24'd4;
      if (stb.write) phase <= ~phase;

      if (stb.setBase) begin
        actWin    <= hitIdx;
        baseValid <= 1'b1;
      end
      if (stb.setDone) doneQ <= 1'b1;
      if (stb.setFail) begin
        errQ    <= 1'b1;
        errOpQ  <= opQ;
        errIdxQ <= cmdIdx;
      end
    end
  end
endmodule

// File: rtl/cmd_stream_exec.sv
module cmd_stream_exec
  import cse_pkg::*;
#(
  parameter int IDXW    = 10,
  parameter int NUM_WIN = 4,
  localparam int WINW   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [IDXW-1:0]         bufLen,
  output logic [IDXW-1:0]         bufRdAddr,
  input  logic [31:0]             bufRdData,
  input  logic [NUM_WIN*24-1:0]   winBase,
  input  logic [NUM_WIN*24-1:0]   winSize,
  output logic                    wrEn,
  output logic [WINW-1:0]         wrWin,
  output logic [23:0]             wrOfs,
  output logic [31:0]             wrData,
  output logic                    busy,
  output logic                    done,
  output logic                    err,
  output logic [7:0]              errOp,
  output logic [IDXW-1:0]         errIdx
);
  strobeT     stb;
  logic [7:0] op;
  logic atEnd, hdrFits, lastHdr, cntZero, cmdFits, contOk, tableOk;
  logic baseHit, scanOk, cntLast, payNone;

  cse_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .atEnd(atEnd),
    .hdrFits(hdrFits), .lastHdr(lastHdr), .cntZero(cntZero),
    .cmdFits(cmdFits), .contOk(contOk), .tableOk(tableOk),
    .baseHit(baseHit), .scanOk(scanOk), .cntLast(cntLast),
    .payNone(payNone), .stb(stb), .busy(busy)
  );

  cse_dpath #(.IDXW(IDXW), .NUM_WIN(NUM_WIN)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .bufLen(bufLen),
    .bufRdData(bufRdData), .winBase(winBase), .winSize(winSize),
    .bufRdAddr(bufRdAddr), .op(op), .atEnd(atEnd), .hdrFits(hdrFits),
    .lastHdr(lastHdr), .cntZero(cntZero), .cmdFits(cmdFits),
    .contOk(contOk), .tableOk(tableOk), .baseHit(baseHit),
    .scanOk(scanOk), .cntLast(cntLast), .payNone(payNone),
    .wrWin(wrWin), .wrOfs(wrOfs), .wrData(wrData), .done(done),
    .err(err), .errOp(errOp), .errIdx(errIdx)
  );

  assign wrEn = stb.write;
endmodule

// File: rtl/cse_checker.sv
module cse_checker #(
  parameter int IDXW    = 10,
  parameter int NUM_WIN = 4,
  localparam int WINW   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  start,
  input logic [IDXW-1:0]       bufLen,
  input logic [IDXW-1:0]       bufRdAddr,
  input logic [NUM_WIN*24-1:0] winSize,
  input logic                  wrEn,
  input logic [WINW-1:0]       wrWin,
  input logic [23:0]           wrOfs,
  input logic                  busy,
  input logic                  done,
  input logic                  err,
  input logic [7:0]            errOp,
  input logic [IDXW-1:0]       errIdx
);
  logic [23:0] namedSize;
  assign namedSize = winSize[wrWin*24 +: 24];

  assert_write_in_window_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (wrOfs < namedSize));

  assert_payload_in_buffer_R11: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (bufRdAddr < bufLen));

  assert_write_only_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> busy);

  assert_no_write_after_err_R12: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !wrEn);

  assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err));

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    (err && !start) |=> err);

  assert_done_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  assert_err_record_stable_R1: assert property (@(posedge clk) disable iff (!rstN)
    (err && !start) |=> ($stable(errOp) && $stable(errIdx)));

  assert_stop_reports_R12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done || err));
endmodule

bind cmd_stream_exec cse_checker #(.IDXW(IDXW), .NUM_WIN(NUM_WIN)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .bufLen(bufLen),
  .bufRdAddr(bufRdAddr), .winSize(winSize), .wrEn(wrEn), .wrWin(wrWin),
  .wrOfs(wrOfs), .busy(busy), .done(done), .err(err), .errOp(errOp),
  .errIdx(errIdx)
);

// File: tb/sim_cmd_stream_exec.sv
module sim_cmd_stream_exec;
  localparam int IDXW = 10;
  localparam int NUM_WIN = 4;
  localparam int WINW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [IDXW-1:0] bufLen = '0;
  logic [IDXW-1:0] bufRdAddr;
  logic [31:0] bufRdData;
  logic [NUM_WIN*24-1:0] winBase, winSize;
  logic wrEn, busy, done, err;
  logic [WINW-1:0] wrWin;
  logic [23:0] wrOfs;
  logic [31:0] wrData;
  logic [7:0] errOp;
  logic [IDXW-1:0] errIdx;

  logic [31:0] mem [0:(1<<IDXW)-1];
  assign bufRdData = mem[bufRdAddr];

  // windows: 0 @0x000100 size 0x40, 1 @0x010000 size 0x100, 2 @0x020000 size 0x1000, 3 @0x030000 size 0x10
  assign winBase = {24'h030000, 24'h020000, 24'h010000, 24'h000100};
  assign winSize = {24'h000010, 24'h001000, 24'h000100, 24'h000040};

  always #10 clk = ~clk;

  cmd_stream_exec #(.IDXW(IDXW), .NUM_WIN(NUM_WIN)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .bufLen(bufLen),
    .bufRdAddr(bufRdAddr), .bufRdData(bufRdData), .winBase(winBase),
    .winSize(winSize), .wrEn(wrEn), .wrWin(wrWin), .wrOfs(wrOfs),
    .wrData(wrData), .busy(busy), .done(done), .err(err),
    .errOp(errOp), .errIdx(errIdx)
  );

  typedef struct {
    int          win;
    int          ofs;
    logic [31:0] data;
    string       tag;
  } expT;

  expT expQ[$];
  int nChecks = 0;
  int nErr = 0;
  int wp = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Monitor: every write is compared against the head of the queue
  always @(negedge clk) begin
    if (rstN && wrEn) begin
      nChecks++;
      if (expQ.size() == 0) begin
        nErr++;
        $display("FAIL R9/R11/R12 unexpected write: actual win=%0d ofs=0x%0h data=0x%0h expected none",
                 wrWin, wrOfs, wrData);
      end else begin
        expT e;
        e = expQ.pop_front();
        if (int'(wrWin) != e.win || int'(wrOfs) != e.ofs || wrData !== e.data) begin
          nErr++;
          $display("FAIL %s write: actual win=%0d ofs=0x%0h data=0x%0h expected win=%0d ofs=0x%0h data=0x%0h",
                   e.tag, wrWin, wrOfs, wrData, e.win, e.ofs, e.data);
        end
      end
    end
  end

  task automatic put(input logic [31:0] w);
    mem[wp] = w;
    wp++;
  endtask

  task automatic expect_wr(input int win, input int ofs, input logic [31:0] d, input string tag);
    expT e;
    e.win = win; e.ofs = ofs; e.data = d; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic cmdBase(input logic [23:0] b);
    put({8'd8, b});
  endtask

  task automatic cmdCont(input int win, input int ofs, input int n, input logic [31:0] seed, input bit ex);
    put({8'd3, 8'd0, 16'(n)});
    put({8'h00, 24'(ofs)});
    for (int k = 0; k < n; k++) begin
      put(seed + 32'(k));
      if (ex) expect_wr(win, ofs + 4*k, seed + 32'(k), "R2");
    end
  endtask

  // Offset words carry 0xAB in [31:24], which must be ignored (R3)
  task automatic cmdRand(input int win, input int ofs0, input int step, input int n, input logic [31:0] seed, input bit ex);
    put({8'd4, 8'd0, 16'(n)});
    for (int k = 0; k < n; k++) begin
      put({8'hAB, 24'(ofs0 + step*k)});
      put(seed + 32'(k));
      if (ex) expect_wr(win, ofs0 + step*k, seed + 32'(k), "R3");
    end
  endtask

  task automatic cmdTbl(input logic [7:0] op, input int win, input int dp, input int len, input logic [31:0] seed, input bit ex);
    int nw;
    put({op, 8'd0, 16'(len)});
    put(32'hDEAD0000);
    put({8'h05, 24'(dp)});
    if (op == 8'd11) nw = ((len + 1) / 8) * 2;
    else             nw = (len + 1) / 4;
    for (int k = 0; k < nw; k++) begin
      put(seed + 32'(k));
      if (ex) begin
        if (op == 8'd1)       expect_wr(win, dp + 8, seed + 32'(k), "R5");
        else if (op == 8'd10) expect_wr(win, dp + 12, seed + 32'(k), "R6");
        else                  expect_wr(win, (k % 2 == 0) ? dp + 12 : dp + 8, seed + 32'(k), "R7");
      end
    end
  endtask

  task automatic runProg(input string req, input bit expErr, input int expOp, input int expIdx);
    int guard;
    bufLen = IDXW'(wp);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    guard = 0;
    while (busy && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk(req, "run finished", 32'(busy), 32'd0);
    chk(req, "done", 32'(done), 32'(!expErr));
    chk(req, "err", 32'(err), 32'(expErr));
    if (expErr) begin
      chk(req, "errOp", 32'(errOp), 32'(expOp));
      chk(req, "errIdx", 32'(errIdx), 32'(expIdx));
    end
    chk(req, "pending writes", 32'(expQ.size()), 32'd0);
    expQ.delete();
    wp = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    int at;
    repeat (3) @(negedge clk);
    // Reset state (R12)
    chk("R12", "reset busy", 32'(busy), 32'd0);
    chk("R12", "reset done", 32'(done), 32'd0);
    chk("R12", "reset err", 32'(err), 32'd0);
    chk("R12", "reset wrEn", 32'(wrEn), 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Full mix on window 1, then window 2 with last legal offset (R2 R3 R5 R6 R7 R8)
    cmdBase(24'h010000);
    cmdCont(1, 'h10, 3, 32'hA000_0000, 1'b1);
    cmdRand(1, 'h80, -'h24, 3, 32'hB000_0000, 1'b1);
    cmdTbl(8'd1, 1, 'h40, 7, 32'hC000_0000, 1'b1);
    cmdTbl(8'd1, 1, 'h40, 2, 32'hC100_0000, 1'b1);   // zero payload words (R5)
    cmdTbl(8'd10, 1, 'h40, 11, 32'hD000_0000, 1'b1);
    cmdTbl(8'd11, 1, 'h20, 15, 32'hE000_0000, 1'b1);
    cmdBase(24'h020000);
    cmdCont(2, 'hFF8, 2, 32'hF000_0000, 1'b1);
    runProg("R8", 1'b0, 0, 0);

    // Unsupported opcode after good commands (R1)
    cmdBase(24'h010000);
    cmdCont(1, 'h0, 1, 32'h1111_0000, 1'b1);
    at = wp; put({8'd5, 24'h0});
    runProg("R1", 1'b1, 5, at);

    // Zero counts (R4)
    cmdBase(24'h010000);
    at = wp; put({8'd4, 24'h0});
    runProg("R4", 1'b1, 4, at);
    cmdBase(24'h010000);
    at = wp; put({8'd3, 24'h0}); put(32'h0);
    runProg("R4", 1'b1, 3, at);

    // Continuous run crossing the window end: no writes at all (R9)
    cmdBase(24'h030000);
    at = wp; cmdCont(3, 'h8, 3, 32'h2222_0000, 1'b0);
    runProg("R9", 1'b1, 3, at);

    // Random list whose second pair is out of range: first pair not written (R9)
    cmdBase(24'h030000);
    at = wp;
    put({8'd4, 8'd0, 16'd2});
    put(32'h0000_0004); put(32'h3333_0000);
    put(32'h0000_0010); put(32'h3333_0001);
    runProg("R9", 1'b1, 4, at);

    // Table offsets near the window end: +8 fits, +12 does not (R9 R5 R6)
    cmdBase(24'h030000);
    cmdTbl(8'd1, 3, 'h4, 3, 32'h4444_0000, 1'b1);
    at = wp; cmdTbl(8'd10, 3, 'h4, 3, 32'h4545_0000, 1'b0);
    runProg("R9", 1'b1, 10, at);

    // Restart clears the window; table load first is an error (R10 R12)
    at = wp; cmdTbl(8'd11, 0, 'h0, 7, 32'h5555_0000, 1'b0);
    runProg("R10", 1'b1, 11, at);

    // Base with no matching window (R8)
    cmdBase(24'h000100);
    cmdCont(0, 'h3C, 1, 32'h6666_0000, 1'b1);
    at = wp; cmdBase(24'h050000);
    runProg("R8", 1'b1, 8, at);

    // Table header cut off by buffer end (R11)
    cmdBase(24'h020000);
    at = wp; put({8'd1, 8'd0, 16'd7});
    runProg("R11", 1'b1, 1, at);

    // Payload longer than the buffer: no writes (R11)
    cmdBase(24'h020000);
    at = wp;
    put({8'd3, 8'd0, 16'd5}); put(32'h0);
    put(32'h7777_0000); put(32'h7777_0001);
    runProg("R11", 1'b1, 3, at);

    // Error stays latched while idle (R12)
    repeat (20) @(negedge clk);
    chk("R12", "err held", 32'(err), 32'd1);
    chk("R12", "errOp held", 32'(errOp), 32'd3);
    chk("R12", "busy idle", 32'(busy), 32'd0);

    // Empty buffer finishes at once (R12)
    runProg("R12", 1'b0, 0, 0);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule